// File: doc/BRIEF.md
# Channel Snapshot Recorder

The recorder sits beside a free-running multi-channel sample stream. Each cycle that `smp_valid` is high, every channel presents one parallel sample on `smp_data`. A host configures the record length, the channel to record and the serial line rate through a small byte-wide register port. One command write then records the requested number of consecutive samples from the chosen channel into on-chip memory. When the last sample is stored, the recorder plays the record back as bytes on a ready/valid output. That output stands in for a serial transmitter. No second command is needed for the playback.

The record length is a power of two, `2^(LEN_BASE_LOG + code)` samples for codes 0 to 4. With `LEN_BASE_LOG = 12` the range is 4096 to 65536 samples. The default of 4 keeps the memory small for elaboration. A separate `buf_rst` input aborts a recording or playback and discards the stored record. It leaves every register setting as it was. `busy` stays high for the whole recording and playback. A long record, or a slow receiver that holds off `tx_ready`, therefore keeps it high longer.

Register map: address 0 holds the length code, address 1 the channel, address 2 the line-rate code. Address 3 is the command on write and the status on read.

Top module: `cap_buffer`

## Requirements
- R1: A write to address 0 with a value from 0 to 4 sets the length code, giving a record of 2^(LEN_BASE_LOG+code) samples. Any other value is rejected and the stored code, read back at address 0, is unchanged.
- R2: A write to address 1 with a value below NUM_CH selects the recorded channel. Channel c occupies bits [c*SAMPLE_W +: SAMPLE_W] of `smp_data`. Larger values are rejected.
- R3: A write of exactly 8'h01 to address 3 while idle starts recording. The status at address 3 then reads 1 in its low two bits (0 idle, 1 recording, 2 playback).
- R4: Recording stores the first valid sample after the command cycle and then each following valid sample, without gaps, until the record is full. Valid samples before the command are not stored.
- R5: Once the record is full, playback starts without a further command (status 2). Each sample is sent as SAMPLE_W/8 bytes, least significant byte first, in recording order. After the last byte the status returns to 0 and `tx_valid` stays low.
- R6: A command written during recording or playback is ignored. The record completes normally and no second record follows.
- R7: `buf_rst` returns the status to 0 and drops `tx_valid` on the next cycle. The length, channel and line-rate registers keep their values.
- R8: A write to address 2 with a value from 0 to 3 sets the line-rate code on `baud_code` (0: 115200, 1: 230400, 2: 460800, 3: 921600). Other values are rejected.
- R9: `busy` is high exactly while the status is 1 or 2.
- R10: The length and channel in force at the command are used for the whole record. Register writes made during recording do not alter it.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of everything |
| buf_rst | input | 1 | Synchronous reset of recording and playback state only |
| smp_valid | input | 1 | Stream sample strobe |
| smp_data | input | NUM_CH*SAMPLE_W | One sample per channel, channel 0 in the low bits |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| busy | output | 1 | Recording or playback in progress |
| baud_code | output | 2 | Line-rate code for the external transmitter |
| tx_valid | output | 1 | Playback byte available |
| tx_data | output | 8 | Playback byte |
| tx_ready | input | 1 | Receiver accepts the byte |

## Verification
The hardest situations to reach are a command or a buffer reset that lands while playback is partway through a record. The bench reaches them by holding `tx_ready` low, so that playback stalls with a byte pending. While it is stalled, the bench issues the stray command or the `buf_rst` pulse and watches the status and the byte stream afterwards. Register writes are also interleaved with the sample feed during recording. This shows that the settings latched at the command, and not the live registers, decide which samples are stored.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } cap_state_e;

    typedef enum logic [1:0] {
        RA_LEN  = 2'd0,
        RA_CHAN = 2'd1,
        RA_BAUD = 2'd2,
        RA_CMD  = 2'd3
    } reg_addr_e;

    localparam int LEN_CODES   = 5;
    localparam int BAUD_CODES  = 4;
    localparam logic [7:0] CMD_START = 8'h01;

    function automatic logic len_code_ok(input logic [7:0] v);
        return v < 8'(LEN_CODES);
    endfunction

    function automatic logic baud_code_ok(input logic [7:0] v);
        return v < 8'(BAUD_CODES);
    endfunction

endpackage

// File: rtl/cap_regs.sv
module cap_regs
    import cap_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  cap_state_e       state,
    output logic [2:0]       len_code,
    output logic [CH_W-1:0]  chan,
    output logic [1:0]       baud,
    output logic             trig,
    output logic [7:0]       rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_code <= '0;
            chan     <= '0;
            baud     <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                RA_LEN:  if (len_code_ok(wdata)) len_code <= wdata[2:0];
                RA_CHAN: if (wdata < 8'(NUM_CH)) chan <= wdata[CH_W-1:0];
                RA_BAUD: if (baud_code_ok(wdata)) baud <= wdata[1:0];
                default: ;
            endcase
        end
    end

    assign trig = we && (reg_addr_e'(addr) == RA_CMD) && (wdata == CMD_START);

    always_comb begin
        case (reg_addr_e'(addr))
            RA_LEN:  rdata = 8'(len_code);
            RA_CHAN: rdata = 8'(chan);
            RA_BAUD: rdata = 8'(baud);
            default: rdata = 8'(state);
        endcase
    end

endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
    parameter int ADDR_W = 8,
    parameter int WIDTH  = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end

endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_W     = 2,
    parameter int SAMPLE_W = 16,
    parameter int ADDR_W   = 8,
    parameter int BIDX_W   = 1,
    parameter int BYTES    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       buf_rst,
    input  logic                       trig,
    input  logic [2:0]                 len_code,
    input  logic [CH_W-1:0]            chan,
    input  logic                       smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       tx_ready,
    output cap_state_e                 state,
    output logic                       wr_en,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [SAMPLE_W-1:0]        wr_data,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic [BIDX_W-1:0]          bidx,
    output logic                       tx_valid
);

    localparam logic [2:0] TOP_CODE = 3'(LEN_CODES - 1);

    logic [ADDR_W-1:0] wcnt, rcnt, cap_last;
    logic [CH_W-1:0]   cap_ch;
    logic              fetch;

    always_ff @(posedge clk) begin
        if (rst || buf_rst) begin
            state    <= ST_IDLE;
            wcnt     <= '0;
            rcnt     <= '0;
            cap_last <= '0;
            cap_ch   <= '0;
            fetch    <= 1'b0;
            tx_valid <= 1'b0;
            bidx     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (trig) begin
                    state    <= ST_FILL;
                    wcnt     <= '0;
                    cap_ch   <= chan;
                    cap_last <= {ADDR_W{1'b1}} >> (TOP_CODE - len_code);
                end
                ST_FILL: if (smp_valid) begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == cap_last) begin
                        state <= ST_DRAIN;
                        rcnt  <= '0;
                        fetch <= 1'b1;
                        bidx  <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (fetch) begin
                        fetch    <= 1'b0;
                        tx_valid <= 1'b1;
                    end else if (tx_valid && tx_ready) begin
                        if (bidx == BIDX_W'(BYTES - 1)) begin
                            bidx     <= '0;
                            tx_valid <= 1'b0;
                            if (rcnt == cap_last) begin
                                state <= ST_IDLE;
                            end else begin
                                rcnt  <= rcnt + 1'b1;
                                fetch <= 1'b1;
                            end
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_en   = (state == ST_FILL) && smp_valid;
    assign wr_addr = wcnt;
    assign wr_data = smp_data[cap_ch*SAMPLE_W +: SAMPLE_W];
    assign rd_addr = rcnt;

endmodule

// File: rtl/cap_buffer.sv
module cap_buffer
    import cap_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int SAMPLE_W     = 16,
    parameter int LEN_BASE_LOG = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       buf_rst,
    input  logic                       smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       reg_we,
    input  logic [1:0]                 reg_addr,
    input  logic [7:0]                 reg_wdata,
    output logic [7:0]                 reg_rdata,
    output logic                       busy,
    output logic [1:0]                 baud_code,
    output logic                       tx_valid,
    output logic [7:0]                 tx_data,
    input  logic                       tx_ready
);

    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ADDR_W = LEN_BASE_LOG + LEN_CODES - 1;
    localparam int BYTES  = SAMPLE_W / 8;
    localparam int BIDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

    cap_state_e          st;
    logic [2:0]          len_code;
    logic [CH_W-1:0]     chan;
    logic                trig;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr, rd_addr;
    logic [SAMPLE_W-1:0] wr_data, rd_q;
    logic [BIDX_W-1:0]   bidx;
    logic [7:0]          lanes [BYTES];

    cap_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .state(st), .len_code(len_code), .chan(chan), .baud(baud_code),
        .trig(trig), .rdata(reg_rdata)
    );

    cap_ctrl #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .SAMPLE_W(SAMPLE_W),
        .ADDR_W(ADDR_W), .BIDX_W(BIDX_W), .BYTES(BYTES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .buf_rst(buf_rst), .trig(trig),
        .len_code(len_code), .chan(chan), .smp_valid(smp_valid),
        .smp_data(smp_data), .tx_ready(tx_ready), .state(st),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .bidx(bidx), .tx_valid(tx_valid)
    );

    cap_mem #(.ADDR_W(ADDR_W), .WIDTH(SAMPLE_W)) u_mem (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(rd_q)
    );

    for (genvar gi = 0; gi < BYTES; gi++) begin : g_lane
        assign lanes[gi] = rd_q[gi*8 +: 8];
    end

    assign tx_data = lanes[bidx];
    assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/cap_buffer_chk.sv
module cap_buffer_chk
    import cap_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       buf_rst,
    input cap_state_e st,
    input logic       trig,
    input logic [2:0] len_code,
    input logic       busy,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data
);

    p_len_legal_r1: assert property (@(posedge clk) disable iff (rst)
        len_code < 3'(LEN_CODES));

    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && trig && !buf_rst) |=> st == ST_FILL);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> !tx_valid);

    p_trig_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && trig && !buf_rst) |=> st != ST_FILL);

    p_bufrst_r7: assert property (@(posedge clk) disable iff (rst)
        buf_rst |=> (st == ST_IDLE && !tx_valid));

    p_busy_tx_r9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst || buf_rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind cap_buffer cap_buffer_chk u_chk (
    .clk(clk), .rst(rst), .buf_rst(buf_rst), .st(st), .trig(trig),
    .len_code(len_code), .busy(busy), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/cap_buffer_tb.sv
module cap_buffer_tb;

    localparam int NUM_CH = 4;
    localparam int SW     = 16;
    localparam int BASE   = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 buf_rst = 1'b0;
    logic                 smp_valid = 1'b0;
    logic [NUM_CH*SW-1:0] smp_data = '0;
    logic                 reg_we = 1'b0;
    logic [1:0]           reg_addr = 2'd0;
    logic [7:0]           reg_wdata = 8'd0;
    logic [7:0]           reg_rdata;
    logic                 busy;
    logic [1:0]           baud_code;
    logic                 tx_valid;
    logic [7:0]           tx_data;
    logic                 tx_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int k = 0;

    always #4 clk = ~clk;

    cap_buffer #(.NUM_CH(NUM_CH), .SAMPLE_W(SW), .LEN_BASE_LOG(BASE)) u_dut (
        .clk(clk), .rst(rst), .buf_rst(buf_rst), .smp_valid(smp_valid),
        .smp_data(smp_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .baud_code(baud_code), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    // code, channel, gap between samples, samples before command, ready delay
    localparam int VEC [4][5] = '{
        '{0, 0, 0, 0, 0},
        '{1, 2, 1, 3, 1},
        '{2, 3, 2, 1, 0},
        '{4, 1, 0, 2, 2}
    };

    function automatic logic [15:0] smp_val(input int c, input int idx);
        return {4'(c), 12'(idx)};
    endfunction

    function automatic logic [NUM_CH*SW-1:0] pack(input int idx);
        logic [NUM_CH*SW-1:0] v;
        for (int c = 0; c < NUM_CH; c++) v[c*SW +: SW] = smp_val(c, idx);
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic feed(input int n, input int gap, input int ch_alt);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b1; smp_data = pack(k);
            if (ch_alt >= 0 && i == n / 2) begin
                reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'(ch_alt);
            end else if (ch_alt >= 0 && i == n / 2 + 1) begin
                reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd0;
            end else if (ch_alt >= 0 && i == n / 2 + 2) begin
                reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h01;
            end
            @(negedge clk);
            smp_valid = 1'b0; reg_we = 1'b0;
            k++;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic run_capture(input int code, input int ch, input int gap,
                               input int pre, input int rdy);
        logic [7:0] d;
        int len, k0, bad, t;
        logic [7:0] held;
        logic [15:0] s;
        len = 1 << (BASE + code);
        wr(2'd0, 8'(code));
        wr(2'd1, 8'(ch));
        feed(pre, 0, -1);
        wr(2'd3, 8'h01);
        rd(2'd3, d);
        chk(d[1:0] == 2'd1, "R3 status after command", d, 1);
        chk(busy == 1'b1, "R9 busy while recording", busy, 1);
        k0 = k;
        feed(len + 3, gap, (ch + 1) % NUM_CH);
        rd(2'd3, d);
        chk(d[1:0] == 2'd2, "R5 playback starts by itself", d, 2);
        wr(2'd3, 8'h01);
        bad = 0;
        for (int j = 0; j < len * 2; j++) begin
            t = 0;
            while (!tx_valid && t < 1000) begin @(negedge clk); t++; end
            if (!tx_valid) begin
                chk(1'b0, "R5 byte never offered", j, len * 2);
                return;
            end
            held = tx_data;
            for (int r = 0; r < rdy; r++) begin
                @(negedge clk);
                if (!tx_valid || tx_data != held) bad++;
            end
            s = smp_val(ch, k0 + j / 2);
            if (tx_data != ((j % 2) ? s[15:8] : s[7:0])) begin
                chk(1'b0, "R4 R10 playback byte", tx_data, (j % 2) ? s[15:8] : s[7:0]);
            end
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
        end
        chk(bad == 0, "R11 byte held while stalled", bad, 0);
        chk(1'b1, "R4 R5 all bytes matched", 0, 0);
        rd(2'd3, d);
        chk(d[1:0] == 2'd0, "R5 idle after last byte", d, 0);
        t = 0;
        repeat (8) begin @(negedge clk); if (tx_valid || busy) t++; end
        chk(t == 0, "R6 no second record", t, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(2'd3, d); chk(d == 8'd0, "R3 reset status idle", d, 0);
        chk(!busy && !tx_valid, "R9 reset outputs low", {busy, tx_valid}, 0);
        rd(2'd0, d); chk(d == 8'd0, "R1 reset length code", d, 0);

        wr(2'd0, 8'd3);
        wr(2'd0, 8'd5);
        rd(2'd0, d); chk(d == 8'd3, "R1 code 5 rejected", d, 3);
        wr(2'd0, 8'd7);
        rd(2'd0, d); chk(d == 8'd3, "R1 code 7 rejected", d, 3);
        wr(2'd0, 8'd4);
        rd(2'd0, d); chk(d == 8'd4, "R1 code 4 accepted", d, 4);
        wr(2'd1, 8'd2);
        wr(2'd1, 8'd4);
        rd(2'd1, d); chk(d == 8'd2, "R2 channel 4 rejected", d, 2);
        wr(2'd2, 8'd3);
        chk(baud_code == 2'd3, "R8 line rate code", baud_code, 3);
        wr(2'd2, 8'd9);
        chk(baud_code == 2'd3, "R8 bad line rate rejected", baud_code, 3);
        wr(2'd3, 8'h03);
        rd(2'd3, d); chk(d == 8'd0, "R3 wrong command value ignored", d, 0);

        for (int v = 0; v < 4; v++)
            run_capture(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

        // buffer reset while recording
        wr(2'd0, 8'd1); wr(2'd1, 8'd1);
        wr(2'd3, 8'h01);
        feed(5, 0, -1);
        buf_rst = 1'b1; @(negedge clk); buf_rst = 1'b0;
        rd(2'd3, d); chk(d == 8'd0, "R7 status idle after buf_rst", d, 0);
        rd(2'd0, d); chk(d == 8'd1, "R7 length kept", d, 1);
        rd(2'd1, d); chk(d == 8'd1, "R7 channel kept", d, 1);
        chk(baud_code == 2'd3, "R7 line rate kept", baud_code, 3);

        // buffer reset while playback is stalled
        wr(2'd0, 8'd0);
        wr(2'd3, 8'h01);
        feed(16, 0, -1);
        repeat (3) @(negedge clk);
        chk(tx_valid == 1'b1, "R5 byte pending", tx_valid, 1);
        buf_rst = 1'b1; @(negedge clk); buf_rst = 1'b0;
        chk(!tx_valid && !busy, "R7 playback aborted", {tx_valid, busy}, 0);
        repeat (5) @(negedge clk);
        chk(!tx_valid, "R7 stays quiet", tx_valid, 0);

        run_capture(0, 1, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule